// File: doc/BRIEF.md
# Counter-Ramp Conversion Sequencer

This block runs a counter-ramp analog-to-digital conversion. It drives an 8-bit code to an external DAC and receives one comparator bit, which stays high for as long as the analog input lies above the DAC level. Each conversion begins at code zero. The code rises by one step per clock until the comparator goes low, or until the code reaches the top of its range. The block then stores the code in a result register, raises a one-cycle valid strobe and starts the ramp again from zero.

The comparator bit is asynchronous to the block clock, so it passes through a synchroniser. Each sample in the synchroniser carries the code that was on the DAC when the sample was taken. The code that is captured is therefore the code that produced the falling comparator, not the later count that is present when the fall is detected. A conversion takes a number of cycles that depends on the input level: low inputs produce closely spaced results and high inputs produce widely spaced ones. An enable input stops the ramp and holds the code at zero.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `dac_code`, `result`, `result_valid` and `overrange` are all zero.
- R2: While enabled, the ramp starts at 0 and `dac_code` rises by exactly one per clock. It never wraps past 8'hFF; it holds there instead.
- R3: The comparator bit is treated as high when the input exceeds the code. `result` is the lowest code for which the comparator was low, which equals the input level for levels 0 to 255.
- R4: `result_valid` is a single-cycle pulse, asserted in the same cycle that `result` takes a new value. `result` does not change in any cycle without the pulse.
- R5: In the cycle `result_valid` is high, `dac_code` is already back at 0, because the ramp has restarted.
- R6: In steady operation, successive `result_valid` pulses are `result` + 3 cycles apart.
- R7: If the comparator is still high when the sample taken at code 8'hFF arrives, `result` becomes 8'hFF with `overrange` = 1. A conversion that ends on a comparator fall sets `overrange` = 0, including a fall at code 8'hFF.
- R8: While `enable` is low, `dac_code` is 0, no `result_valid` pulse occurs and `result` holds its value. Samples taken before the enable dropped are discarded.
- R9: When re-enabled, the first result arrives level + 3 cycles after the first enabled clock edge. An input of 0 completes in 3 cycles with result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the ramp when high |
| cmp_in | input | 1 | Asynchronous comparator bit, high while input exceeds DAC level |
| dac_code | output | 8 | Code driven to the DAC |
| result | output | 8 | Last captured conversion code |
| result_valid | output | 1 | One-cycle strobe marking a new result |
| overrange | output | 1 | Set when the last result ended at full scale without a fall |

## Verification
The ramp is driven by a model comparator that compares a stimulus level with the code, and the bench applies a series of levels. A level of zero exercises a conversion whose very first sample is already low, which is where an edge detector without priming would hang. The levels 1, 37 and 128 check that the captured code is compensated for the synchroniser latency and that the spacing between results grows with the level. The levels 254, 255, 256 and 400 separate a genuine fall at the top code from full-scale overrange. A separate test drops the enable in the middle of a ramp, which shows that stale samples in the synchroniser are discarded and that the restart timing is correct.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

    localparam int CODE_W = 8;
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    typedef logic [CODE_W-1:0] code_t;

    // One synchroniser sample: the comparator bit, the code that produced it,
    // and whether it belongs to the current ramp.
    typedef struct packed {
        logic  vld;
        logic  cmp;
        code_t tag;
    } sample_t;

    typedef enum logic [1:0] {
        CAP_NONE = 2'd0,
        CAP_FALL = 2'd1,
        CAP_OVER = 2'd2
    } cap_e;

    function automatic logic is_top(code_t c);
        return c == CODE_MAX;
    endfunction

endpackage

// File: rtl/ramp_counter.sv
module ramp_counter
    import ramp_adc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  clr,
    output code_t code
);

    always_ff @(posedge clk) begin
        if (rst || clr || !en) begin
            code <= '0;
        end else if (!is_top(code)) begin
            code <= code + 1'b1;
        end
    end

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && !is_top(code)) |=> (code == $past(code) + 1'b1));

    p_no_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && is_top(code)) |=> is_top(code));

    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (code == '0));

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> (code == '0));

endmodule

// File: rtl/ramp_sync_pipe.sv
module ramp_sync_pipe
    import ramp_adc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    flush,
    input  logic    cmp_raw,
    input  code_t   code_in,
    output sample_t smp_out
);

    sample_t stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage[0] <= '0;
        end else begin
            stage[0].cmp <= cmp_raw;
            stage[0].tag <= code_in;
            stage[0].vld <= !flush;
        end
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage[i] <= '0;
            end else begin
                stage[i].cmp <= stage[i-1].cmp;
                stage[i].tag <= stage[i-1].tag;
                stage[i].vld <= stage[i-1].vld && !flush;
            end
        end
    end

    assign smp_out = stage[STAGES-1];

    p_flush_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> !smp_out.vld);

endmodule

// File: rtl/ramp_fall_detect.sv
module ramp_fall_detect
    import ramp_adc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  sample_t smp,
    output cap_e    kind
);

    // The previous level is primed high whenever no valid sample is present,
    // so the first low sample of a ramp still counts as a fall.
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= smp.vld ? smp.cmp : 1'b1;
        end
    end

    always_comb begin
        kind = CAP_NONE;
        if (en && smp.vld) begin
            if (prev_q && !smp.cmp) begin
                kind = CAP_FALL;
            end else if (smp.cmp && is_top(smp.tag)) begin
                kind = CAP_OVER;
            end
        end
    end

    p_over_top_r7: assert property (@(posedge clk) disable iff (rst)
        (kind == CAP_OVER) |-> (smp.cmp && is_top(smp.tag)));

endmodule

// File: rtl/ramp_capture.sv
module ramp_capture
    import ramp_adc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cap_e  kind,
    input  code_t tag,
    output code_t result,
    output logic  valid,
    output logic  ovr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            valid  <= 1'b0;
            ovr    <= 1'b0;
        end else begin
            valid <= (kind != CAP_NONE);
            if (kind != CAP_NONE) begin
                result <= tag;
                ovr    <= (kind == CAP_OVER);
            end
        end
    end

    p_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(result));

    p_ovr_full_r7: assert property (@(posedge clk) disable iff (rst)
        ovr |-> (result == CODE_MAX));

endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
    import ramp_adc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              cmp_in,
    output logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] result,
    output logic              result_valid,
    output logic              overrange
);

    code_t   code;
    sample_t smp;
    cap_e    kind;
    logic    restart;
    logic    flush;

    assign restart = (kind != CAP_NONE);
    assign flush   = restart || !enable;

    ramp_counter u_counter (
        .clk  (clk),
        .rst  (rst),
        .en   (enable),
        .clr  (restart),
        .code (code)
    );

    ramp_sync_pipe #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .cmp_raw (cmp_in),
        .code_in (code),
        .smp_out (smp)
    );

    ramp_fall_detect u_detect (
        .clk  (clk),
        .rst  (rst),
        .en   (enable),
        .smp  (smp),
        .kind (kind)
    );

    ramp_capture u_capture (
        .clk    (clk),
        .rst    (rst),
        .kind   (kind),
        .tag    (smp.tag),
        .result (result),
        .valid  (result_valid),
        .ovr    (overrange)
    );

    assign dac_code = code;

    p_tag_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (kind != CAP_NONE) |=> (result == $past(smp.tag)));

    p_valid_zero_r5: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (dac_code == '0));

    p_no_cap_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !result_valid);

endmodule

// File: tb/test_ramp_adc_ctrl.sv
module test_ramp_adc_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       cmp_in;
    logic [7:0] dac_code;
    logic [7:0] result;
    logic       result_valid;
    logic       overrange;
    int         level = 0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    // Behavioural DAC plus comparator
    assign cmp_in = (level > int'(dac_code));

    ramp_adc_ctrl i_ramp_adc_ctrl (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .cmp_in       (cmp_in),
        .dac_code     (dac_code),
        .result       (result),
        .result_valid (result_valid),
        .overrange    (overrange)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_valid(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!result_valid && n < 2000);
        chk(result_valid, "R6 timeout waiting for result", n, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        enable = 1'b0;
        repeat (3) @(negedge clk);
        chk(dac_code == 8'd0, "R1 dac_code", dac_code, 0);
        chk(result == 8'd0, "R1 result", result, 0);
        chk(result_valid == 1'b0, "R1 result_valid", result_valid, 0);
        chk(overrange == 1'b0, "R1 overrange", overrange, 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_ramp_step();
        level = 300;
        enable = 1'b1;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            chk(dac_code == 8'(i), "R2 ramp step", dac_code, i);
        end
    endtask

    task automatic t_saturate();
        int seen;
        seen = 0;
        level = 300;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (dac_code == 8'hFF) seen++;
            if (result_valid) break;
        end
        // Code FF is held for the cycles the last sample spends in flight
        chk(seen == 3, "R2 hold at top code", seen, 3);
    endtask

    task automatic t_convert(input int lvl);
        int n;
        int exp;
        level = lvl;
        exp = (lvl > 255) ? 255 : lvl;
        wait_valid(n);
        wait_valid(n);
        wait_valid(n);
        chk(result == 8'(exp), "R3 result code", result, exp);
        chk(overrange == (lvl > 255), "R7 overrange flag", overrange, int'(lvl > 255));
        chk(n == exp + 3, "R6 result spacing", n, exp + 3);
        chk(dac_code == 8'd0, "R5 restart code", dac_code, 0);
        @(negedge clk);
        chk(result_valid == 1'b0, "R4 single pulse", result_valid, 0);
        chk(result == 8'(exp), "R4 result held", result, exp);
    endtask

    task automatic t_enable();
        int n;
        logic [7:0] held;
        int bad_v;
        int bad_c;
        level = 300;
        wait_valid(n);
        repeat (50) @(negedge clk);
        held = result;
        enable = 1'b0;
        bad_v = 0;
        bad_c = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (result_valid) bad_v++;
            if (dac_code != 8'd0) bad_c++;
        end
        chk(bad_v == 0, "R8 no strobe while disabled", bad_v, 0);
        chk(bad_c == 0, "R8 code zero while disabled", bad_c, 0);
        chk(result == held, "R8 result held while disabled", result, held);
        level = 20;
        enable = 1'b1;
        wait_valid(n);
        chk(n == 23, "R9 first result latency", n, 23);
        chk(result == 8'd20, "R9 first result code", result, 20);
        level = 0;
        wait_valid(n);
        wait_valid(n);
        chk(n == 3, "R9 zero-level spacing", n, 3);
        chk(result == 8'd0, "R9 zero-level result", result, 0);
    endtask

    initial begin
        t_reset();
        t_ramp_step();
        t_saturate();
        t_convert(0);
        t_convert(1);
        t_convert(37);
        t_convert(128);
        t_convert(254);
        t_convert(255);
        t_convert(256);
        t_convert(400);
        t_convert(9);
        t_enable();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule